// File: doc/BRIEF.md
# Amplitude Window Search Controller

This controller trims the bias current of a crystal oscillator so that the oscillation amplitude ends up between two analog thresholds. Two external comparators report whether the sensed peak is below the lower threshold (`amp_low`) or above the upper threshold (`amp_high`). The controller adjusts an 8-bit bias word using successive halving. It starts from mid-scale and applies a step of a quarter of full scale, and the step halves after every decision.

The crystal's high Q makes the amplitude settle slowly, so the controller waits a fixed settling interval before it samples the comparators. The interval is a parameter counted in cycles of the oscillator-derived clock. The search ends in one of two ways: the amplitude lands inside the window, or the step size runs out. After that the bias word is frozen and `done` is high.

A start-up boost flag is high from reset until the first decision. Analog logic outside this block uses it to speed up oscillation start.

Top module: `amp_search_ctrl`

## Requirements
- R1: While reset is asserted, `bias_word` is 128, `done` is 0 and `boost` is 1. The internal step size restarts at 64.
- R2: `bias_word` changes only at the clock edge that ends a settling interval. That edge is the SETTLE_CYCLES-th rising edge after reset release or after the previous decision.
- R3: If only `amp_low` is high at the end of an interval, `bias_word` increases by the current step.
- R4: If only `amp_high` is high at the end of an interval, `bias_word` decreases by the current step.
- R5: The step size halves after every decision that is not a lock, so steps go 64, 32, 16, 8, 4, 2, 1.
- R6: If both flags are low at the end of an interval, `done` rises and `bias_word` keeps its value.
- R7: If both flags are high at the end of an interval, `bias_word` keeps its value, the step still halves, and the search continues.
- R8: After the decision that uses step 1, `done` rises even if the amplitude is not inside the window.
- R9: Once `done` is high, the flags have no effect: `bias_word` and `done` stay constant until reset.
- R10: `boost` stays high from reset until the first decision edge and stays low after that edge.
- R11: The flags pass through a two-flop synchronizer. Only their value at least two cycles before the end of the interval matters; earlier values within the interval are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock derived from the running oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| amp_low | input | 1 | Amplitude is below the lower threshold (asynchronous) |
| amp_high | input | 1 | Amplitude is above the upper threshold (asynchronous) |
| bias_word | output | WORD_W | Bias current control word |
| done | output | 1 | Search finished; word frozen |
| boost | output | 1 | Start-up current boost request |

## Verification
The bound checker watches four things on every cycle:
- the bias word changes only on the edge that closes an interval;
- every change has a magnitude that is a power of two;
- the word and `done` stay frozen once `done` is high;
- `boost` never comes back after it falls, and it is already low on the edge of the first word change.

Only the bench scenarios can show that the search follows the right path and gives the right direction and final value for each flag pattern. This includes the fault case with both flags high, exhaustion at the top and bottom of the range, an alternating search, and a late flag change that decides a step.

// File: rtl/amp_search_pkg.sv
package amp_search_pkg;

  // Decision taken at the end of a settling interval.
  typedef enum logic [1:0] {
    DEC_FAULT = 2'd0,  // both comparators active: hold word, advance step
    DEC_RAISE = 2'd1,  // amplitude too small
    DEC_LOWER = 2'd2,  // amplitude too large
    DEC_LOCK  = 2'd3   // inside the window
  } step_dec_t;

  function automatic step_dec_t decide(input logic too_low, input logic too_high);
    case ({too_low, too_high})
      2'b10:   return DEC_RAISE;
      2'b01:   return DEC_LOWER;
      2'b00:   return DEC_LOCK;
      default: return DEC_FAULT;
    endcase
  endfunction

endpackage

// File: rtl/amp_flag_sync.sv
module amp_flag_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/amp_settle_timer.sv
module amp_settle_timer #(
  parameter int CYCLES = 75000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/amp_search_core.sv
module amp_search_core
  import amp_search_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              too_low,
  input  logic              too_high,
  output logic [WORD_W-1:0] word,
  output logic              done,
  output logic              boost
);

  localparam logic [WORD_W-1:0] MID   = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] STEP0 = WORD_W'(1) << (WORD_W - 2);
  localparam logic [WORD_W-1:0] ONE   = WORD_W'(1);

  logic [WORD_W-1:0] step;
  step_dec_t         dec;
  logic              act;

  assign dec = decide(too_low, too_high);
  assign act = tick && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= MID;
      step  <= STEP0;
      done  <= 1'b0;
      boost <= 1'b1;
    end else if (act) begin
      boost <= 1'b0;
      if (dec == DEC_LOCK) begin
        done <= 1'b1;
      end else begin
        if (dec == DEC_RAISE) word <= word + step;
        if (dec == DEC_LOWER) word <= word - step;
        step <= step >> 1;
        if (step == ONE) done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/amp_search_ctrl.sv
module amp_search_ctrl #(
  parameter int WORD_W        = 8,
  parameter int SETTLE_CYCLES = 75000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              amp_low,
  input  logic              amp_high,
  output logic [WORD_W-1:0] bias_word,
  output logic              done,
  output logic              boost
);

  logic [1:0] flags_s;
  logic       tick;

  amp_flag_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({amp_low, amp_high}),
    .q_sync  (flags_s)
  );

  amp_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (!done),
    .tick  (tick)
  );

  amp_search_core #(.WORD_W(WORD_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .too_low  (flags_s[1]),
    .too_high (flags_s[0]),
    .word     (bias_word),
    .done     (done),
    .boost    (boost)
  );

endmodule

// File: rtl/amp_search_ctrl_chk.sv
module amp_search_ctrl_chk #(
  parameter int WORD_W        = 8,
  parameter int SETTLE_CYCLES = 75000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] bias_word,
  input logic              done,
  input logic              boost
);

  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [WORD_W-1:0] MID = WORD_W'(1) << (WORD_W - 1);

  logic [CW-1:0]     phase;
  logic [WORD_W-1:0] prev_word;
  logic [WORD_W-1:0] delta;

  // Independent interval phase counter; 0 right after each interval end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      prev_word <= MID;
    end else begin
      phase     <= (phase == CW'(SETTLE_CYCLES - 1)) ? '0 : phase + 1'b1;
      prev_word <= bias_word;
    end
  end

  assign delta = (bias_word > prev_word) ? (bias_word - prev_word) : (prev_word - bias_word);

  // R2: a word change is seen only just after an interval end
  a_r2_change_on_interval: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_word != prev_word) |-> (phase == '0));

  // R5: every adjustment is a single power-of-two step
  a_r5_power_of_two_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_word != prev_word) |-> ($countones(delta) == 1));

  // R9: frozen once finished
  a_r9_frozen_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(bias_word)));

  // R10: boost never returns after it drops
  a_r10_boost_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    !boost |=> !boost);

  // R10: boost is already off when the word first moves
  a_r10_boost_off_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_word != prev_word) |-> !boost);

endmodule

bind amp_search_ctrl amp_search_ctrl_chk #(
  .WORD_W        (WORD_W),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bias_word (bias_word),
  .done      (done),
  .boost     (boost)
);

// File: tb/amp_search_ctrl_bench.sv
`timescale 1ns/1ps
module amp_search_ctrl_bench;

  localparam int W = 8;
  localparam int S = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         amp_low = 1'b0;
  logic         amp_high = 1'b0;
  logic [W-1:0] bias_word;
  logic         done;
  logic         boost;

  always #10 clk = ~clk;

  amp_search_ctrl #(.WORD_W(W), .SETTLE_CYCLES(S)) u_amp_search_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .amp_low   (amp_low),
    .amp_high  (amp_high),
    .bias_word (bias_word),
    .done      (done),
    .boost     (boost)
  );

  int checks = 0;
  int errors = 0;
  int edge_cnt;
  bit finished = 1'b0;

  logic [W-1:0] q_word[$];
  bit           q_done[$];
  string        q_tag[$];
  logic [W-1:0] last_word = 8'd128;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compares at each interval end; checks hold one cycle before.
  always @(negedge clk) begin
    if (rst_n && edge_cnt > 0) begin
      if ((edge_cnt % S) == 0 && q_word.size() > 0) begin
        logic [W-1:0] w;
        bit d;
        string t;
        w = q_word.pop_front();
        d = q_done.pop_front();
        t = q_tag.pop_front();
        check(bias_word == w, t, "bias_word", bias_word, w);
        check(done == d, t, "done", done, d);
        check(boost == 1'b0, "R10", "boost after first step", boost, 0);
        last_word = w;
      end else if ((edge_cnt % S) == S - 1) begin
        check(bias_word == last_word, "R2", "word held inside interval", bias_word, last_word);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    amp_low = 1'b0;
    amp_high = 1'b0;
    q_word.delete();
    q_done.delete();
    q_tag.delete();
    repeat (3) @(negedge clk);
    check(bias_word == 8'd128, "R1", "reset word", bias_word, 128);
    check(done == 1'b0, "R1", "reset done", done, 0);
    check(boost == 1'b1, "R10", "reset boost", boost, 1);
    last_word = 8'd128;
    rst_n = 1'b1;
  endtask

  // Driver: U=low only, D=high only, N=none, B=both, X=high early then low late.
  task automatic run_seq(input string seq);
    int exp_word = 128;
    int exp_step = 64;
    bit exp_done = 1'b0;
    for (int k = 1; k <= seq.len(); k++) begin
      byte c;
      string tag;
      c = seq[k-1];
      while (edge_cnt != (k - 1) * S + 1) @(negedge clk);
      amp_low  = (c == "U") || (c == "B");
      amp_high = (c == "D") || (c == "B") || (c == "X");
      if (exp_done) begin
        tag = "R9 ignored after done";
      end else if (c == "N") begin
        exp_done = 1'b1;
        tag = "R6 lock";
      end else begin
        if (c == "U") begin exp_word += exp_step; tag = "R3 raise"; end
        if (c == "X") begin exp_word += exp_step; tag = "R11 late flag"; end
        if (c == "D") begin exp_word -= exp_step; tag = "R4 lower"; end
        if (c == "B") tag = "R7 fault hold";
        if (exp_step == 1) begin
          exp_done = 1'b1;
          tag = {tag, " R8 exhausted"};
        end
        exp_step = exp_step / 2;
        tag = {tag, " R5"};
      end
      q_word.push_back(exp_word[W-1:0]);
      q_done.push_back(exp_done);
      q_tag.push_back(tag);
      if (c == "X") begin
        while (edge_cnt != k * S - 4) @(negedge clk);
        amp_low  = 1'b1;
        amp_high = 1'b0;
      end
    end
    while (edge_cnt != seq.len() * S + 2) @(negedge clk);
    check(q_word.size() == 0, "R2", "all steps observed", q_word.size(), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    run_seq("UDNUD");
    do_reset();
    run_seq("UUUUUUUU");
    do_reset();
    run_seq("DDDDDDDU");
    do_reset();
    run_seq("BXNU");
    do_reset();
    run_seq("DUDUDUDN");
    summary();
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    summary();
  end

endmodule